// File: doc/BRIEF.md
# Partial-Tag Associative Row Decoder for a Two-Dimensional Cache Block

This block performs the tag lookup for one macro-block of a highly associative cache. The blocks are laid out as a grid of rows and columns, 128 by 8 by default. Every column keeps, for each of its rows, a short low-order slice of the tag in associative cells. The rest of the tag is held in plain storage beside it. A lookup searches all columns in parallel. In each column, the matching slice acts as the row decoder and selects a single row. The remaining tag bits of that row are then compared with the lookup address to decide whether the column holds the line.

A fill port writes a tag and a valid flag into a chosen row and column. The outputs are registered and appear one cycle after the request, so the hit latency is constant:

- a per-column partial-match vector, which the miss handler uses to pick a victim;
- a hit flag;
- the hit row and the hit column.

The fill logic must never place two valid entries with the same slice in one column. The design depends on that rule, and assertions guard it.

Top module: `pcam_lookup`

## Requirements
- R1: After reset every entry is invalid: a lookup of any address returns hit_o=0, pmatch_o=0, hit_row_o=0 and hit_col_o=0.
- R2: The address splits into three fields. Bits [6:0] are the byte offset and are ignored. The tag is bits [47:7]. The associative slice is tag[11:0], which is address bits [18:7]. The remaining tag is tag[40:12], which is address bits [47:19]. The fill tag uses the same layout: fill_tag_i[11:0] is the slice and fill_tag_i[40:12] is the remaining tag.
- R3: pmatch_o[c] is 1 when column c holds a valid entry whose slice equals the lookup slice; bit c corresponds to column c.
- R4: hit_o is 1 only when a single entry matches on both its slice and its remaining tag. A slice match whose remaining tag differs sets pmatch_o but leaves hit_o at 0.
- R5: On a hit, hit_row_o and hit_col_o give the location of the matching entry, including the edge rows 0 and ROWS-1 and the edge columns 0 and COLS-1. On a miss, both are 0.
- R6: A fill with fill_valid_i=1 stores the entry at the posedge where fill_en_i is high. A lookup requested in the next cycle finds it.
- R7: A fill with fill_valid_i=0 invalidates the addressed entry. A later lookup of its tag gets no partial match or hit from that entry.
- R8: The outputs are registered. They reflect the lookup requested in the previous cycle. After a cycle with lookup_valid_i=0, all outputs are 0.
- R9: Several columns may hold the same slice, and each of them raises its own pmatch_o bit. The hit goes to the one column whose remaining tag matches. Within a column, at most one valid entry may hold a given slice. At most one column may report a full match. When several columns do report a full match, the lowest-indexed one is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request this cycle |
| lookup_addr_i | input | ADDR_W (48) | Byte address to look up |
| fill_en_i | input | 1 | Write one entry this cycle |
| fill_row_i | input | ROW_W (7) | Row of the entry to write |
| fill_col_i | input | COL_W (3) | Column of the entry to write |
| fill_tag_i | input | TAG_W (41) | Tag to store: slice in the low bits, remaining tag above |
| fill_valid_i | input | 1 | Valid flag to store |
| pmatch_o | output | COLS (8) | Per-column slice match for the previous lookup |
| hit_o | output | 1 | Full tag match for the previous lookup |
| hit_row_o | output | ROW_W (7) | Row of the hit |
| hit_col_o | output | COL_W (3) | Column of the hit |

## Verification
The bench loads a handful of entries and then runs a table of lookups against them. The table separates the following cases:

- a full hit from a slice match with a different remaining tag;
- one slice held in two columns, with the hit landing in one or the other;
- entries at the corner rows and columns;
- addresses that differ only in the offset bits;
- slices that are not stored anywhere.

Directed sequences then check four more behaviours:

- an empty lookup straight after reset;
- a fill followed by a lookup in the very next cycle;
- an invalidating fill;
- an idle cycle that must clear the registered outputs.

Together these show that the row decode, the remaining-tag comparison and the output register each contribute their own part of the result.

// File: rtl/pcam_pkg.sv
package pcam_pkg;
  localparam int unsigned DEF_ADDR_W   = 48;
  localparam int unsigned DEF_OFFSET_W = 7;
  localparam int unsigned DEF_ROWS     = 128;
  localparam int unsigned DEF_COLS     = 8;
  localparam int unsigned DEF_SLICE_W  = 12;
endpackage

// File: rtl/pcam_prio.sv
// Lowest-index-first encoder over a request vector.
module pcam_prio #(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/pcam_column.sv
// One column: associative slice per row decodes the row, plain storage holds the rest.
module pcam_column #(
  parameter int unsigned ROWS    = 128,
  parameter int unsigned SLICE_W = 12,
  parameter int unsigned REST_W  = 29,
  localparam int unsigned ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ROW_W-1:0]   wrow_i,
  input  logic [SLICE_W-1:0] wslice_i,
  input  logic [REST_W-1:0]  wrest_i,
  input  logic               wvalid_i,
  input  logic [SLICE_W-1:0] qslice_i,
  input  logic [REST_W-1:0]  qrest_i,
  output logic               pmatch_o,
  output logic               full_o,
  output logic [ROW_W-1:0]   row_o
);
  logic [ROWS-1:0]    valid_q;
  logic [SLICE_W-1:0] slice_q [ROWS];
  logic [REST_W-1:0]  rest_q  [ROWS];
  logic [ROWS-1:0]    row_match;
  logic               any_row;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (we_i) begin
      valid_q[wrow_i] <= wvalid_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      slice_q[wrow_i] <= wslice_i;
      rest_q[wrow_i]  <= wrest_i;
    end
  end

  // associative row decoder
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_match[r] = valid_q[r] && (slice_q[r] == qslice_i);
  end

  pcam_prio #(.N(ROWS)) i_row_enc (
    .req_i (row_match),
    .any_o (any_row),
    .idx_o (row_o)
  );

  assign pmatch_o = any_row;
  assign full_o   = any_row && (rest_q[row_o] == qrest_i);

  p_unique_slice_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_match));

  p_fill_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (valid_q[$past(wrow_i)] == $past(wvalid_i)));
endmodule

// File: rtl/pcam_lookup.sv
module pcam_lookup
  import pcam_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned OFFSET_W = DEF_OFFSET_W,
  parameter int unsigned ROWS     = DEF_ROWS,
  parameter int unsigned COLS     = DEF_COLS,
  parameter int unsigned SLICE_W  = DEF_SLICE_W,
  localparam int unsigned TAG_W   = ADDR_W - OFFSET_W,
  localparam int unsigned REST_W  = TAG_W - SLICE_W,
  localparam int unsigned ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned COL_W   = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  input  logic              fill_en_i,
  input  logic [ROW_W-1:0]  fill_row_i,
  input  logic [COL_W-1:0]  fill_col_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic              fill_valid_i,
  output logic [COLS-1:0]   pmatch_o,
  output logic              hit_o,
  output logic [ROW_W-1:0]  hit_row_o,
  output logic [COL_W-1:0]  hit_col_o
);
  logic [TAG_W-1:0]   q_tag;
  logic [SLICE_W-1:0] q_slice;
  logic [REST_W-1:0]  q_rest;
  logic [COLS-1:0]    col_pm;
  logic [COLS-1:0]    col_full;
  logic [ROW_W-1:0]   col_row [COLS];
  logic               any_full;
  logic [COL_W-1:0]   full_col;

  assign q_tag   = lookup_addr_i[ADDR_W-1:OFFSET_W];
  assign q_slice = q_tag[SLICE_W-1:0];
  assign q_rest  = q_tag[TAG_W-1:SLICE_W];

  for (genvar c = 0; c < COLS; c++) begin : g_col
    pcam_column #(
      .ROWS    (ROWS),
      .SLICE_W (SLICE_W),
      .REST_W  (REST_W)
    ) i_col (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (fill_en_i && (fill_col_i == COL_W'(c))),
      .wrow_i   (fill_row_i),
      .wslice_i (fill_tag_i[SLICE_W-1:0]),
      .wrest_i  (fill_tag_i[TAG_W-1:SLICE_W]),
      .wvalid_i (fill_valid_i),
      .qslice_i (q_slice),
      .qrest_i  (q_rest),
      .pmatch_o (col_pm[c]),
      .full_o   (col_full[c]),
      .row_o    (col_row[c])
    );
  end

  pcam_prio #(.N(COLS)) i_col_sel (
    .req_i (col_full),
    .any_o (any_full),
    .idx_o (full_col)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pmatch_o  <= '0;
      hit_o     <= 1'b0;
      hit_row_o <= '0;
      hit_col_o <= '0;
    end else if (lookup_valid_i) begin
      pmatch_o  <= col_pm;
      hit_o     <= any_full;
      hit_row_o <= any_full ? col_row[full_col] : '0;
      hit_col_o <= any_full ? full_col : '0;
    end else begin
      pmatch_o  <= '0;
      hit_o     <= 1'b0;
      hit_row_o <= '0;
      hit_col_o <= '0;
    end
  end

  p_one_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(col_full));

  p_hit_has_pmatch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> pmatch_o[hit_col_o]);

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> (!hit_o && (pmatch_o == '0)));

  p_miss_zero_loc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (hit_row_o == '0 && hit_col_o == '0));
endmodule

// File: tb/test_pcam_lookup.sv
`timescale 1ns/1ps
module test_pcam_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookup_valid = 1'b0;
  logic [47:0] lookup_addr = '0;
  logic        fill_en = 1'b0;
  logic [6:0]  fill_row = '0;
  logic [2:0]  fill_col = '0;
  logic [40:0] fill_tag = '0;
  logic        fill_valid = 1'b0;
  logic [7:0]  pmatch;
  logic        hit;
  logic [6:0]  hit_row;
  logic [2:0]  hit_col;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcam_lookup i_pcam_lookup (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .lookup_valid_i (lookup_valid),
    .lookup_addr_i  (lookup_addr),
    .fill_en_i      (fill_en),
    .fill_row_i     (fill_row),
    .fill_col_i     (fill_col),
    .fill_tag_i     (fill_tag),
    .fill_valid_i   (fill_valid),
    .pmatch_o       (pmatch),
    .hit_o          (hit),
    .hit_row_o      (hit_row),
    .hit_col_o      (hit_col)
  );

  localparam int NV = 9;
  localparam logic [28:0] t_rest  [NV] = '{29'h00ABCDE, 29'h1111111, 29'h0002222, 29'h1FFFFFFF,
                                           29'h0000000, 29'h0000777, 29'h0000000, 29'h00ABCDE,
                                           29'h00ABCDE};
  localparam logic [11:0] t_slice [NV] = '{12'h123, 12'h123, 12'h123, 12'hFFF, 12'h000,
                                           12'h456, 12'h789, 12'h124, 12'h123};
  localparam logic [6:0]  t_off   [NV] = '{7'h55, 7'h00, 7'h11, 7'h7F, 7'h00, 7'h3C, 7'h00,
                                           7'h00, 7'h00};
  localparam logic [7:0]  t_pm    [NV] = '{8'h09, 8'h09, 8'h09, 8'h80, 8'h04, 8'h20, 8'h00,
                                           8'h00, 8'h09};
  localparam logic        t_hit   [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [6:0]  t_row   [NV] = '{7'd5, 7'd100, 7'd0, 7'd127, 7'd0, 7'd64, 7'd0, 7'd0,
                                           7'd5};
  localparam logic [2:0]  t_col   [NV] = '{3'd0, 3'd3, 3'd0, 3'd7, 3'd2, 3'd5, 3'd0, 3'd0, 3'd0};
  localparam string       t_req   [NV] = '{"R2 R3 R5", "R9", "R4", "R5 edge", "R5 row0",
                                           "R3", "R3 none", "R4 slice", "R2 offset"};

  task automatic check(input string req, input logic [18:0] got, input logic [18:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got pm/hit/row/col=%h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [18:0] pack(input logic [7:0] pm, input logic h,
                                       input logic [6:0] r, input logic [2:0] c);
    return {pm, h, r, c};
  endfunction

  task automatic do_fill(input logic [2:0] c, input logic [6:0] r, input logic [28:0] rest,
                         input logic [11:0] sl, input logic v);
    @(negedge clk);
    fill_en = 1'b1; fill_col = c; fill_row = r; fill_tag = {rest, sl}; fill_valid = v;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_lookup(input logic [47:0] a);
    @(negedge clk);
    lookup_valid = 1'b1; lookup_addr = a;
    @(negedge clk);
    lookup_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    do_lookup({29'h0, 12'h000, 7'h00});
    check("R1 reset", pack(pmatch, hit, hit_row, hit_col), '0);

    do_fill(3'd0, 7'd5,   29'h00ABCDE,  12'h123, 1'b1);
    do_fill(3'd3, 7'd100, 29'h1111111,  12'h123, 1'b1);
    do_fill(3'd7, 7'd127, 29'h1FFFFFFF, 12'hFFF, 1'b1);
    do_fill(3'd2, 7'd0,   29'h0000000,  12'h000, 1'b1);
    do_fill(3'd5, 7'd64,  29'h0000777,  12'h456, 1'b1);

    for (int i = 0; i < NV; i++) begin
      do_lookup({t_rest[i], t_slice[i], t_off[i]});
      check(t_req[i], pack(pmatch, hit, hit_row, hit_col),
            pack(t_pm[i], t_hit[i], t_row[i], t_col[i]));
    end

    // R6: fill then lookup in the very next cycle
    @(negedge clk);
    fill_en = 1'b1; fill_col = 3'd1; fill_row = 7'd9; fill_tag = {29'h0000ABC, 12'h9A0};
    fill_valid = 1'b1;
    @(negedge clk);
    fill_en = 1'b0;
    lookup_valid = 1'b1; lookup_addr = {29'h0000ABC, 12'h9A0, 7'h01};
    @(negedge clk);
    lookup_valid = 1'b0;
    check("R6 fill next cycle", pack(pmatch, hit, hit_row, hit_col),
          pack(8'h02, 1'b1, 7'd9, 3'd1));

    // R7: invalidate column 0 row 5
    do_fill(3'd0, 7'd5, 29'h00ABCDE, 12'h123, 1'b0);
    do_lookup({29'h00ABCDE, 12'h123, 7'h00});
    check("R7 invalidate", pack(pmatch, hit, hit_row, hit_col),
          pack(8'h08, 1'b0, 7'd0, 3'd0));

    // R8: one-cycle latency, then idle clears outputs
    @(negedge clk);
    lookup_valid = 1'b1; lookup_addr = {29'h1FFFFFFF, 12'hFFF, 7'h00};
    @(negedge clk);
    lookup_valid = 1'b0;
    check("R8 latency", pack(pmatch, hit, hit_row, hit_col),
          pack(8'h80, 1'b1, 7'd127, 3'd7));
    @(negedge clk);
    check("R8 idle", pack(pmatch, hit, hit_row, hit_col), '0);

    // R9: the slice still held in column 3 hits after column 0 was removed
    do_lookup({29'h1111111, 12'h123, 7'h40});
    check("R9 remaining column", pack(pmatch, hit, hit_row, hit_col),
          pack(8'h08, 1'b1, 7'd100, 3'd3));

    finish_run();
  end
endmodule